// File: doc/BRIEF.md
# Relocatable-Slot Priority Interrupt Encoder

This block picks one interrupt out of a 32-level priority table for a communications coprocessor and hands it to the core as a 5-bit code. Most levels belong to a fixed source: port pins, timers, DMA channels, the DMA bus-error line, SPI, I2C and the two serial management controllers. Four levels are relocatable slots (a to d). A mapping field decides which of four high-speed channels fills each slot: channel 0 is the USB controller and channels 1 to 3 are serial controllers. A layout bit decides where slots b, c and d sit in the table. When the bit is clear they are grouped just under slot a. When it is set they are spread lower down.

Each source has a pending bit and a mask bit. Every clock the block registers the highest unmasked pending code and raises a request to the core. The core answers with an acknowledge strobe. The strobe moves the reported code into an in-service register and clears the pending bit of the source behind it. The layout bit is taken in only while the controller is disabled. The mapping field can be rewritten at any time. A mapping that gives one channel to two slots is refused and flagged.

Top module: `prio_slot_pic`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `irq`, `vector`, `in_service` and `map_err` are all zero. Reset loads the mapping slot a=0, b=1, c=2, d=3 and the grouped layout.
- R2: One clock edge after a request, `vector` shows the highest code whose pending and mask bits are both set, and `irq` is high. When no such code exists, `irq` and `vector` are 0. Code 0 is never reported.
- R3: `fix_req`/`fix_mask` bit k belongs to the fixed source at code k. The fixed codes are 0x1F, 0x1A to 0x14, 0x12 to 0x10, 0x0F, 0x0E, 0x0C to 0x09 and 0x07 to 0x01. A request bit at any other position is ignored. A masked source keeps its pending bit but is not reported.
- R4: Slot a is always at code 0x1E. In the grouped layout (layout bit 0), slots b, c and d are at 0x1D, 0x1C and 0x1B.
- R5: In the spread layout (layout bit 1), slots b, c and d are at 0x13, 0x0D and 0x08, and codes 0x1D to 0x1B carry no source.
- R6: `spread_mode` is sampled only on edges where `enable` is low. While `enable` is low, `irq` and `vector` are 0, all pending bits are cleared and new requests are not held.
- R7: Bits [2s+1:2s] of `slot_map` give the channel number for slot s (s=0 is a, up to s=3 is d). A valid new mapping is used at the very next arbitration edge.
- R8: A mapping that names the same channel in two slots is not used. The previous valid mapping stays in force, and `map_err` is 1 on the following cycle.
- R9: An `ack` on a cycle when `irq` is high loads `in_service` with the current `vector` and clears the pending bit of the source behind that code. A request on the same line in the same cycle keeps the bit set.
- R10: An `ack` on a cycle when `irq` is low has no effect: `in_service` and all pending bits stay as they are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| enable | input | 1 | controller enable; layout bit is sampled while low |
| spread_mode | input | 1 | 0 grouped layout, 1 spread layout |
| slot_map | input | 8 | channel number for each of slots a..d |
| fix_req | input | 32 | request lines of fixed sources, indexed by code |
| fix_mask | input | 32 | mask bits of fixed sources, 1 = enabled |
| chan_req | input | 4 | request lines of relocatable channels 0..3 |
| chan_mask | input | 4 | mask bits of relocatable channels, 1 = enabled |
| ack | input | 1 | core acknowledge strobe |
| irq | output | 1 | request to the core |
| vector | output | 5 | code of the reported source |
| in_service | output | 5 | code last acknowledged |
| map_err | output | 1 | last presented mapping had a duplicate channel |

## Verification
The bench builds the block with its default parameters: 32 levels, 5-bit codes and four relocatable channels with 2-bit numbers. The table and both layouts are therefore covered exactly as specified. With only four channels, a random 8-bit mapping often holds a duplicate, so invalid mappings, hold-over of the last good mapping, and remapping during live traffic all occur in the random phase. The random phase also toggles the enable, which moves the layout between grouped and spread. This tests slot positions, the gap left at 0x1D to 0x1B, and acknowledge clears against both layouts.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int LEVELS = 32;
  localparam int CODE_W = $clog2(LEVELS);
  localparam int NCH    = 4;
  localparam int CH_W   = $clog2(NCH);
  localparam int MAP_W  = NCH * CH_W;

  // one bit per code that has a source wired to it permanently
  localparam logic [LEVELS-1:0] FIXED_CODES = 32'h87F7_DEFE;

  // code occupied by relocatable slot s in the chosen layout
  function automatic logic [CODE_W-1:0] slot_code(input int s, input logic spread);
    logic [CODE_W-1:0] c;
    case (s)
      0:       c = 5'h1E;
      1:       c = spread ? 5'h13 : 5'h1D;
      2:       c = spread ? 5'h0D : 5'h1C;
      default: c = spread ? 5'h08 : 5'h1B;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pic_slot_map.sv
module pic_slot_map
  import pic_pkg::*;
#(
  parameter int N_CH = NCH,
  parameter int C_W  = CH_W,
  localparam int M_W = N_CH * C_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [M_W-1:0] map_in,
  output logic [M_W-1:0] map_eff,
  output logic           err
);
  logic [M_W-1:0] map_q;
  logic           dup;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < N_CH; i++)
      for (int j = i + 1; j < N_CH; j++)
        if (map_in[i*C_W +: C_W] == map_in[j*C_W +: C_W]) dup = 1'b1;
  end

  assign map_eff = dup ? map_q : map_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < N_CH; s++) map_q[s*C_W +: C_W] <= C_W'(s);
      err <= 1'b0;
    end else begin
      map_q <= map_eff;
      err   <= dup;
    end
  end

  // R8: a refused mapping leaves the stored mapping unchanged
  p_hold_on_dup_r8: assert property (@(posedge clk) disable iff (rst)
    err |-> $stable(map_q));

  // R7/R8: each channel appears exactly once in the stored mapping
  generate
    for (genvar c = 0; c < N_CH; c++) begin : g_chk
      logic [N_CH-1:0] hit;
      for (genvar s = 0; s < N_CH; s++) begin : g_s
        assign hit[s] = (map_q[s*C_W +: C_W] == C_W'(c));
      end
      p_map_perm_r7: assert property (@(posedge clk) disable iff (rst)
        $countones(hit) == 1);
    end
  endgenerate
endmodule

// File: rtl/pic_gather.sv
module pic_gather
  import pic_pkg::*;
#(
  parameter int N_LVL = LEVELS,
  parameter int N_CH  = NCH,
  parameter int C_W   = CH_W,
  localparam int M_W  = N_CH * C_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_LVL-1:0] fix_pend,
  input  logic [N_LVL-1:0] fix_mask,
  input  logic [N_CH-1:0]  chan_pend,
  input  logic [N_CH-1:0]  chan_mask,
  input  logic [M_W-1:0]   map_eff,
  input  logic             spread,
  output logic [N_LVL-1:0] elig
);
  logic [N_LVL-1:0] slot_elig;

  always_comb begin
    slot_elig = '0;
    for (int s = 0; s < N_CH; s++) begin
      if (chan_pend[map_eff[s*C_W +: C_W]] && chan_mask[map_eff[s*C_W +: C_W]])
        slot_elig[slot_code(s, spread)] = 1'b1;
    end
  end

  assign elig = (fix_pend & fix_mask & FIXED_CODES) | slot_elig;

  // R5: nothing sits in the grouped gap while spread
  p_spread_gap_r5: assert property (@(posedge clk) disable iff (rst)
    spread |-> (elig[29:27] == 3'b000));
  // R2: the reserved bottom level is never eligible
  p_level0_r2: assert property (@(posedge clk) disable iff (rst)
    !elig[0]);
endmodule

// File: rtl/pic_prio_enc.sv
module pic_prio_enc #(
  parameter int N   = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (req[k]) begin
        idx = IW'(k);
        any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/prio_slot_pic.sv
module prio_slot_pic
  import pic_pkg::*;
#(
  parameter int N_LVL = LEVELS,
  parameter int N_CH  = NCH,
  localparam int C_W  = $clog2(N_CH),
  localparam int V_W  = $clog2(N_LVL),
  localparam int M_W  = N_CH * C_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             spread_mode,
  input  logic [M_W-1:0]   slot_map,
  input  logic [N_LVL-1:0] fix_req,
  input  logic [N_LVL-1:0] fix_mask,
  input  logic [N_CH-1:0]  chan_req,
  input  logic [N_CH-1:0]  chan_mask,
  input  logic             ack,
  output logic             irq,
  output logic [V_W-1:0]   vector,
  output logic [V_W-1:0]   in_service,
  output logic             map_err
);
  logic [N_LVL-1:0] fix_pend_q, fix_pend_d, fix_clr, elig;
  logic [N_CH-1:0]  chan_pend_q, chan_pend_d, chan_clr;
  logic [M_W-1:0]   map_eff;
  logic             mode_q, rep_is_ch_q, rep_is_ch_d, any, ack_go;
  logic [C_W-1:0]   rep_ch_q, rep_ch_d;
  logic [V_W-1:0]   win;

  assign ack_go = ack & irq;

  always_comb begin
    fix_clr  = '0;
    chan_clr = '0;
    if (ack_go) begin
      if (rep_is_ch_q) chan_clr[rep_ch_q] = 1'b1;
      else             fix_clr[vector]    = 1'b1;
    end
    fix_pend_d  = enable ? ((fix_pend_q & ~fix_clr) | (fix_req & FIXED_CODES)) : '0;
    chan_pend_d = enable ? ((chan_pend_q & ~chan_clr) | chan_req) : '0;
  end

  pic_slot_map #(.N_CH(N_CH), .C_W(C_W)) u_map (
    .clk(clk), .rst(rst), .map_in(slot_map), .map_eff(map_eff), .err(map_err)
  );

  pic_gather #(.N_LVL(N_LVL), .N_CH(N_CH), .C_W(C_W)) u_gather (
    .clk(clk), .rst(rst), .fix_pend(fix_pend_d), .fix_mask(fix_mask),
    .chan_pend(chan_pend_d), .chan_mask(chan_mask), .map_eff(map_eff),
    .spread(mode_q), .elig(elig)
  );

  pic_prio_enc #(.N(N_LVL)) u_enc (.req(elig), .idx(win), .any(any));

  // which channel, if any, stands behind the winning code
  always_comb begin
    rep_is_ch_d = 1'b0;
    rep_ch_d    = '0;
    for (int s = 0; s < N_CH; s++) begin
      if (slot_code(s, mode_q) == win) begin
        rep_is_ch_d = 1'b1;
        rep_ch_d    = map_eff[s*C_W +: C_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fix_pend_q  <= '0;
      chan_pend_q <= '0;
      mode_q      <= 1'b0;
      irq         <= 1'b0;
      vector      <= '0;
      in_service  <= '0;
      rep_is_ch_q <= 1'b0;
      rep_ch_q    <= '0;
    end else begin
      fix_pend_q  <= fix_pend_d;
      chan_pend_q <= chan_pend_d;
      if (!enable) mode_q <= spread_mode;
      irq         <= enable & any;
      vector      <= (enable & any) ? win : '0;
      rep_is_ch_q <= rep_is_ch_d;
      rep_ch_q    <= rep_ch_d;
      if (ack_go) in_service <= vector;
    end
  end

  p_irq_code_r2: assert property (@(posedge clk) disable iff (rst)
    irq |-> (vector != '0));
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !irq |-> (vector == '0));
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !irq);
  p_mode_held_r6: assert property (@(posedge clk) disable iff (rst)
    enable |=> $stable(mode_q));
  p_ack_load_r9: assert property (@(posedge clk) disable iff (rst)
    (ack && irq) |=> (in_service == $past(vector)));
  p_ack_idle_r10: assert property (@(posedge clk) disable iff (rst)
    !(ack && irq) |=> $stable(in_service));
endmodule

// File: tb/prio_slot_pic_tb.sv
module prio_slot_pic_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SEED = 1234;

  logic clk = 0, rst = 1, enable = 0, spread_mode = 0, ack = 0;
  logic [7:0] slot_map = 8'b11_10_01_00;
  logic [31:0] fix_req = 0, fix_mask = '1;
  logic [3:0] chan_req = 0, chan_mask = '1;
  logic irq, map_err;
  logic [4:0] vector, in_service;

  int checks = 0, fails = 0, cyc = 0;
  string tag = "R1";

  // model state
  logic [31:0] m_fp; logic [3:0] m_cp; logic m_mode; logic [7:0] m_map;
  logic m_err, m_irq, m_rep_is_ch; logic [4:0] m_vec, m_isvc; logic [1:0] m_rep_ch;

  prio_slot_pic u_dut (.clk(clk), .rst(rst), .enable(enable), .spread_mode(spread_mode),
    .slot_map(slot_map), .fix_req(fix_req), .fix_mask(fix_mask), .chan_req(chan_req),
    .chan_mask(chan_mask), .ack(ack), .irq(irq), .vector(vector),
    .in_service(in_service), .map_err(map_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 50000);
    fails++; checks++;
    $display("FAIL watchdog: expired act=hung exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic bit tb_fixed(input int c);
    case (c)
      31, 26, 25, 24, 23, 22, 21, 20, 18, 17, 16, 15, 14,
      12, 11, 10, 9, 7, 6, 5, 4, 3, 2, 1: return 1;
      default: return 0;
    endcase
  endfunction

  // slot index living at code c, or -1
  function automatic int tb_slot(input int c, input logic sp);
    if (c == 30) return 0;
    if (!sp) begin
      if (c == 29) return 1;
      if (c == 28) return 2;
      if (c == 27) return 3;
    end else begin
      if (c == 19) return 1;
      if (c == 13) return 2;
      if (c == 8)  return 3;
    end
    return -1;
  endfunction

  task automatic model_reset();
    m_fp = 0; m_cp = 0; m_mode = 0; m_map = 8'b11_10_01_00; m_err = 0;
    m_irq = 0; m_vec = 0; m_isvc = 0; m_rep_ch = 0; m_rep_is_ch = 0;
  endtask

  task automatic model_edge();
    logic [31:0] fclr; logic [3:0] cclr; logic [7:0] meff; bit dup; int s;
    fclr = 0; cclr = 0;
    if (ack && m_irq) begin
      m_isvc = m_vec;
      if (m_rep_is_ch) cclr[m_rep_ch] = 1; else fclr[m_vec] = 1;
    end
    dup = 0;
    for (int i = 0; i < 4; i++)
      for (int j = i + 1; j < 4; j++)
        if (slot_map[2*i +: 2] == slot_map[2*j +: 2]) dup = 1;
    meff = dup ? m_map : slot_map;
    m_map = meff; m_err = dup;
    if (!enable) begin
      m_fp = 0; m_cp = 0;
    end else begin
      m_fp = (m_fp & ~fclr);
      for (int c = 0; c < 32; c++) if (fix_req[c] && tb_fixed(c)) m_fp[c] = 1;
      m_cp = (m_cp & ~cclr) | chan_req;
    end
    m_irq = 0; m_vec = 0; m_rep_is_ch = 0; m_rep_ch = 0;
    if (enable) begin
      for (int c = 31; c >= 1; c--) begin
        s = tb_slot(c, m_mode);
        if (!m_irq) begin
          if (tb_fixed(c) && m_fp[c] && fix_mask[c]) begin
            m_irq = 1; m_vec = 5'(c);
          end else if (s >= 0 && m_cp[meff[2*s +: 2]] && chan_mask[meff[2*s +: 2]]) begin
            m_irq = 1; m_vec = 5'(c); m_rep_is_ch = 1; m_rep_ch = meff[2*s +: 2];
          end
        end
      end
    end
    if (!enable) m_mode = spread_mode;
  endtask

  task automatic compare();
    checks++;
    if (irq !== m_irq || vector !== m_vec) begin
      fails++;
      $display("FAIL %s cyc %0d: irq/vector act=%0b/%h exp=%0b/%h", tag, cyc, irq, vector, m_irq, m_vec);
    end
    checks++;
    if (in_service !== m_isvc) begin
      fails++;
      $display("FAIL %s cyc %0d: in_service act=%h exp=%h", tag, cyc, in_service, m_isvc);
    end
    checks++;
    if (map_err !== m_err) begin
      fails++;
      $display("FAIL %s cyc %0d: map_err act=%0b exp=%0b", tag, cyc, map_err, m_err);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model_reset(); else model_edge();
    @(negedge clk);
    cyc++;
    compare();
    fix_req = 0; chan_req = 0; ack = 0;
  endtask

  task automatic direct(input string t, input bit cond, input int act, input int exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: act=%h exp=%h", t, act, exp);
    end
  endtask

  task automatic reenable(input logic sp);
    enable = 0; spread_mode = sp; step();
    enable = 1; step();
  endtask

  initial begin
    void'($urandom(SEED));
    model_reset();
    @(negedge clk);
    tag = "R1"; step(); step();
    rst = 0; step();
    direct("R1 reset outputs", {irq, vector, in_service, map_err} == 0,
           {irq, vector, in_service, map_err}, 0);

    // R4 grouped slots
    tag = "R4"; reenable(0);
    chan_req = 4'b0010; step();
    direct("R4 slot b grouped", vector == 5'h1D, vector, 5'h1D);
    ack = 1; step();
    chan_req = 4'b0001; fix_req[31] = 1; fix_mask[31] = 0; step();
    direct("R4 slot a", vector == 5'h1E, vector, 5'h1E);
    // R3 masked source stays pending, unmask later
    tag = "R3"; ack = 1; step();
    direct("R3 masked hidden", irq == 0, irq, 0);
    fix_mask[31] = 1; step();
    direct("R3 unmask pending", vector == 5'h1F, vector, 5'h1F);
    ack = 1; step();
    fix_req = 32'h7000_2101; step();
    direct("R3 unused codes ignored", irq == 0, irq, 0);

    // R5 spread layout; R6 mode change while enabled ignored
    tag = "R5"; reenable(1);
    chan_req = 4'b1110; step();
    direct("R5 slot b spread", vector == 5'h13, vector, 5'h13);
    ack = 1; step(); ack = 1; step();
    direct("R5 slot d spread", vector == 5'h08, vector, 5'h08);
    tag = "R6"; spread_mode = 0; ack = 1; step();
    chan_req = 4'b0100; step();
    direct("R6 layout held", vector == 5'h0D, vector, 5'h0D);
    enable = 0; step();
    direct("R6 disabled quiet", irq == 0, irq, 0);

    // R7 remap; R8 duplicate refused
    tag = "R7"; reenable(0);
    chan_req = 4'b1000; step();
    direct("R7 ch3 in slot d", vector == 5'h1B, vector, 5'h1B);
    slot_map = 8'b00_10_01_11; step();
    direct("R7 ch3 moved to a", vector == 5'h1E, vector, 5'h1E);
    tag = "R8"; slot_map = 8'b01_10_01_00; step();
    direct("R8 flag", map_err == 1, map_err, 1);
    direct("R8 old map kept", vector == 5'h1E, vector, 5'h1E);
    // R9 ack with simultaneous re-request keeps pending
    tag = "R9"; ack = 1; chan_req = 4'b1000; step();
    direct("R9 in_service", in_service == 5'h1E, in_service, 5'h1E);
    direct("R9 still pending", vector == 5'h1E, vector, 5'h1E);
    ack = 1; step();
    // R10 ack while idle
    tag = "R10"; ack = 1; step();
    direct("R10 idle ack", in_service == 5'h1E, in_service, 5'h1E);

    // random mix
    tag = "R2";
    for (int n = 0; n < 4000; n++) begin
      fix_req   = $urandom() & $urandom() & $urandom();
      chan_req  = 4'($urandom() & $urandom());
      fix_mask  = ($urandom_range(0, 3) == 0) ? $urandom() : '1;
      chan_mask = ($urandom_range(0, 3) == 0) ? 4'($urandom()) : 4'hF;
      ack = ($urandom_range(0, 2) != 0);
      if ($urandom_range(0, 15) == 0) slot_map = 8'($urandom());
      if ($urandom_range(0, 63) == 0) enable = ~enable;
      spread_mode = 1'($urandom());
      step();
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule